// File: doc/BRIEF.md
# Status-polled NOR flash erase and byte-program sequencer

This block drives a simple synchronous bus towards a NOR flash that uses a write-command, read-status protocol. On a start pulse it runs either a block erase or a single-byte program: it first writes a reset command to the device's command address, then issues a two-write command pair at the target byte address, and then reads the status byte from the target address until the ready bit is set or a cycle watchdog expires.

The outcome is reported as a two-bit result code together with the last status byte read. A ready status with any fault bit set is a device fault; a busy status that persists past the selected cycle limit is a timeout. Only a clean completion is followed by a closing reset write that returns the device to read-array mode. The command address is a parameter, shifted left by one when the device sits on the bus in 16-bit mode; the target address is always driven unchanged.

The flash returns read data one clock after the read strobe, and the sequencer samples it in that cycle.

Top module: `flashseq_engine`

## Requirements
- R1: During and right after reset, busy, done, bus_wr and bus_rd are 0, result is 2'b00 and status is 8'h00.
- R2: Every operation begins with a write of 8'hFF to the command address, which is CMD_OFS when wide16 is 0 and CMD_OFS shifted left by one bit when wide16 is 1; the target address is never shifted.
- R3: An erase (op = 0) writes 8'h20 and then 8'hD0, both to the target address, right after the opening reset write.
- R4: A program (op = 1) writes 8'h40 and then the data byte, both to the target address, right after the opening reset write.
- R5: After the command pair the block reads the status from the target address, one read every two cycles, while status bit 7 is 0.
- R6: A status read with bit 7 set and bits 6:0 zero ends the operation with result 2'b00, preceded by a final write of 8'hFF to the command address.
- R7: A status read with bit 7 set and any of bits 6:0 set ends the operation with result 2'b01 and no closing write.
- R8: A poll counter starts at 0 on the first status read cycle and counts every poll cycle, so the k-th status is judged at count 2k-1; a busy status judged at a count not below the limit ends the operation with result 2'b10 and no closing write, while a ready status is always accepted.
- R9: The limit used is erase_limit for an erase and prog_limit for a program, sampled at start.
- R10: After done, status holds the last byte read from the device for every result, until the next accepted start.
- R11: A start pulse while busy is high is ignored: the running operation's addresses, data and command are unchanged.
- R12: busy is high from the cycle after an accepted start through the done cycle; done is high for exactly one cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| start | input | 1 | Begin an operation when idle |
| op | input | 1 | 0 = block erase, 1 = byte program |
| wide16 | input | 1 | Device on a 16-bit bus: command address doubled |
| addr | input | AW | Target byte address |
| data | input | 8 | Byte to program |
| erase_limit | input | TW | Poll cycle limit for erase |
| prog_limit | input | TW | Poll cycle limit for program |
| bus_wr | output | 1 | Bus write strobe |
| bus_rd | output | 1 | Bus read strobe |
| bus_addr | output | AW | Bus address |
| bus_wdata | output | 8 | Bus write data |
| bus_rdata | input | 8 | Bus read data, valid the cycle after bus_rd |
| busy | output | 1 | Operation in progress |
| done | output | 1 | One-cycle completion pulse |
| result | output | 2 | 00 ok, 01 device fault, 10 timeout |
| status | output | 8 | Last status byte read |

## Verification
A table of erase and program operations is run against a bench flash model that stays busy for a chosen number of reads and then answers with chosen fault bits. Entries with zero, few and many busy reads separate the clean, fault and timeout paths, and the full write log tells the erase pair from the program pair and shows whether the closing reset write is present. A pair of entries with limits 7 and 8 and four busy reads pins the exact poll count at which a timeout fires, a zero limit with an immediately ready device shows that ready wins, and the unused limit is always 0 so a wrong limit choice ends in a one-read timeout. Separate runs cover 16-bit command addressing, a start pulse in mid-operation and the reset state.

// File: rtl/flashseq_pkg.sv
package flashseq_pkg;

  typedef enum logic [2:0] {
    S_IDLE,
    S_RESET,
    S_CMD1,
    S_CMD2,
    S_POLL_RD,
    S_POLL_WT,
    S_EXIT,
    S_FIN
  } seq_state_t;

  typedef enum logic [1:0] {
    RES_OK      = 2'b00,
    RES_DEVICE  = 2'b01,
    RES_TIMEOUT = 2'b10
  } seq_result_t;

  localparam logic [7:0] CMD_READ_ARRAY = 8'hFF;
  localparam logic [7:0] CMD_ERASE_SET  = 8'h20;
  localparam logic [7:0] CMD_ERASE_GO   = 8'hD0;
  localparam logic [7:0] CMD_PROG_SET   = 8'h40;

endpackage

// File: rtl/flashseq_watchdog.sv
module flashseq_watchdog #(
  parameter int TW = 24
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          run,
  input  logic [TW-1:0] limit,
  output logic          expired
);
  logic [TW-1:0] count;

  always_ff @(posedge clk) begin
    if (rst || !run) begin
      count <= '0;
    end else if (count != {TW{1'b1}}) begin
      count <= count + 1'b1;
    end
  end

  assign expired = run && (count >= limit);

  // R8: the counter restarts at zero whenever polling is not running
  p_count_clear_r8: assert property (@(posedge clk) disable iff (rst)
    !run |=> (count == '0));

endmodule

// File: rtl/flashseq_judge.sv
module flashseq_judge #(
  parameter int DW = 8
) (
  input  logic [DW-1:0] stat,
  output logic          ready,
  output logic          fault
);
  assign ready = stat[DW-1];
  assign fault = stat[DW-1] && (|stat[DW-2:0]);
endmodule

// File: rtl/flashseq_ctrl.sv
module flashseq_ctrl
  import flashseq_pkg::*;
#(
  parameter int          AW      = 24,
  parameter int          TW      = 24,
  parameter int unsigned CMD_OFS = 0
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          start,
  input  logic          op,
  input  logic          wide16,
  input  logic [AW-1:0] addr,
  input  logic [7:0]    data,
  input  logic [TW-1:0] erase_limit,
  input  logic [TW-1:0] prog_limit,
  input  logic [7:0]    rdata,
  input  logic          ready,
  input  logic          fault,
  input  logic          expired,
  output logic          poll_run,
  output logic [TW-1:0] limit,
  output logic          bus_wr,
  output logic          bus_rd,
  output logic [AW-1:0] bus_addr,
  output logic [7:0]    bus_wdata,
  output logic          busy,
  output logic          done,
  output logic [1:0]    result,
  output logic [7:0]    status
);
  localparam logic [AW-1:0] CMD_BASE = AW'(CMD_OFS);

  seq_state_t    state;
  seq_result_t   res_q;
  logic          op_q;
  logic          w16_q;
  logic [AW-1:0] addr_q;
  logic [7:0]    data_q;
  logic [TW-1:0] lim_q;
  logic [7:0]    stat_q;
  logic [AW-1:0] cmd_addr;

  always_ff @(posedge clk) begin
    if (rst) begin
      state  <= S_IDLE;
      res_q  <= RES_OK;
      op_q   <= 1'b0;
      w16_q  <= 1'b0;
      addr_q <= '0;
      data_q <= '0;
      lim_q  <= '0;
      stat_q <= '0;
    end else begin
      unique case (state)
        S_IDLE: begin
          if (start) begin
            op_q   <= op;
            w16_q  <= wide16;
            addr_q <= addr;
            data_q <= data;
            lim_q  <= op ? prog_limit : erase_limit;
            res_q  <= RES_OK;
            stat_q <= '0;
            state  <= S_RESET;
          end
        end
        S_RESET:   state <= S_CMD1;
        S_CMD1:    state <= S_CMD2;
        S_CMD2:    state <= S_POLL_RD;
        S_POLL_RD: state <= S_POLL_WT;
        S_POLL_WT: begin
          if (ready) begin
            stat_q <= rdata;
            if (fault) begin
              res_q <= RES_DEVICE;
              state <= S_FIN;
            end else begin
              res_q <= RES_OK;
              state <= S_EXIT;
            end
          end else if (expired) begin
            stat_q <= rdata;
            res_q  <= RES_TIMEOUT;
            state  <= S_FIN;
          end else begin
            state <= S_POLL_RD;
          end
        end
        S_EXIT:  state <= S_FIN;
        S_FIN:   state <= S_IDLE;
        default: state <= S_IDLE;
      endcase
    end
  end

  assign cmd_addr = w16_q ? {CMD_BASE[AW-2:0], 1'b0} : CMD_BASE;

  always_comb begin
    bus_wr    = 1'b0;
    bus_wdata = CMD_READ_ARRAY;
    bus_addr  = addr_q;
    unique case (state)
      S_RESET, S_EXIT: begin
        bus_wr   = 1'b1;
        bus_addr = cmd_addr;
      end
      S_CMD1: begin
        bus_wr    = 1'b1;
        bus_wdata = op_q ? CMD_PROG_SET : CMD_ERASE_SET;
      end
      S_CMD2: begin
        bus_wr    = 1'b1;
        bus_wdata = op_q ? data_q : CMD_ERASE_GO;
      end
      default: ;
    endcase
  end

  assign bus_rd   = (state == S_POLL_RD);
  assign poll_run = (state == S_POLL_RD) || (state == S_POLL_WT);
  assign limit    = lim_q;
  assign busy     = (state != S_IDLE);
  assign done     = (state == S_FIN);
  assign result   = res_q;
  assign status   = stat_q;

  // R11: a start seen while busy leaves the latched operation untouched
  p_start_ignored_r11: assert property (@(posedge clk) disable iff (rst)
    (state != S_IDLE) |=> ($stable(addr_q) && $stable(op_q) && $stable(data_q)));

  // R6: a clean ready status is followed by the closing reset write
  p_exit_write_r6: assert property (@(posedge clk) disable iff (rst)
    (state == S_POLL_WT && ready && !fault) |=>
      (bus_wr && bus_wdata == CMD_READ_ARRAY && bus_addr == cmd_addr));

  // R7: a fault goes straight to completion with no bus write
  p_fault_no_write_r7: assert property (@(posedge clk) disable iff (rst)
    (state == S_POLL_WT && fault) |=> (!bus_wr && done));

  // R5: polling reads are spaced two cycles apart
  p_read_spacing_r5: assert property (@(posedge clk) disable iff (rst)
    bus_rd |=> !bus_rd);

endmodule

// File: rtl/flashseq_engine.sv
module flashseq_engine #(
  parameter int          AW      = 24,
  parameter int          TW      = 24,
  parameter int unsigned CMD_OFS = 0
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          start,
  input  logic          op,
  input  logic          wide16,
  input  logic [AW-1:0] addr,
  input  logic [7:0]    data,
  input  logic [TW-1:0] erase_limit,
  input  logic [TW-1:0] prog_limit,
  output logic          bus_wr,
  output logic          bus_rd,
  output logic [AW-1:0] bus_addr,
  output logic [7:0]    bus_wdata,
  input  logic [7:0]    bus_rdata,
  output logic          busy,
  output logic          done,
  output logic [1:0]    result,
  output logic [7:0]    status
);
  logic          ready;
  logic          fault;
  logic          expired;
  logic          poll_run;
  logic [TW-1:0] limit;

  flashseq_judge #(.DW(8)) u_judge (
    .stat  (bus_rdata),
    .ready (ready),
    .fault (fault)
  );

  flashseq_watchdog #(.TW(TW)) u_watchdog (
    .clk     (clk),
    .rst     (rst),
    .run     (poll_run),
    .limit   (limit),
    .expired (expired)
  );

  flashseq_ctrl #(.AW(AW), .TW(TW), .CMD_OFS(CMD_OFS)) u_ctrl (
    .clk         (clk),
    .rst         (rst),
    .start       (start),
    .op          (op),
    .wide16      (wide16),
    .addr        (addr),
    .data        (data),
    .erase_limit (erase_limit),
    .prog_limit  (prog_limit),
    .rdata       (bus_rdata),
    .ready       (ready),
    .fault       (fault),
    .expired     (expired),
    .poll_run    (poll_run),
    .limit       (limit),
    .bus_wr      (bus_wr),
    .bus_rd      (bus_rd),
    .bus_addr    (bus_addr),
    .bus_wdata   (bus_wdata),
    .busy        (busy),
    .done        (done),
    .result      (result),
    .status      (status)
  );

  // R5: read and write strobes never coincide
  p_strobe_excl_r5: assert property (@(posedge clk) disable iff (rst)
    !(bus_wr && bus_rd));

  // R12: done lasts one cycle and ends the busy period
  p_done_pulse_r12: assert property (@(posedge clk) disable iff (rst)
    done |=> (!done && !busy));

  // R2: the first cycle of busy is the opening reset write
  p_open_write_r2: assert property (@(posedge clk) disable iff (rst)
    $rose(busy) |-> (bus_wr && bus_wdata == 8'hFF));

  // R8: a timeout result always carries a busy status byte
  p_timeout_busy_r8: assert property (@(posedge clk) disable iff (rst)
    (done && result == 2'b10) |-> !status[7]);

  // R7: a fault result carries ready plus a nonzero fault field
  p_fault_bits_r7: assert property (@(posedge clk) disable iff (rst)
    (done && result == 2'b01) |-> (status[7] && status[6:0] != 7'd0));

endmodule

// File: tb/test_flashseq_engine.sv
module test_flashseq_engine;
  localparam int AW = 24;
  localparam int TW = 24;
  localparam int unsigned CMD_OFS = 5;

  typedef struct packed {
    logic        op;
    logic        w16;
    logic [23:0] adr;
    logic [7:0]  dat;
    logic [7:0]  nbusy;
    logic [6:0]  fbits;
    logic [15:0] lim;
  } vec_t;

  localparam int NV = 9;
  localparam vec_t VECS [NV] = '{
    '{1'b0, 1'b0, 24'h012000, 8'h00, 8'd3,  7'h00, 16'd100},
    '{1'b1, 1'b1, 24'h000345, 8'hA5, 8'd0,  7'h00, 16'd50},
    '{1'b1, 1'b0, 24'h00FFFF, 8'h3C, 8'd2,  7'h10, 16'd100},
    '{1'b0, 1'b1, 24'h7F0000, 8'h00, 8'd10, 7'h00, 16'd5},
    '{1'b1, 1'b0, 24'h000010, 8'h5A, 8'd0,  7'h00, 16'd0},
    '{1'b0, 1'b0, 24'h020000, 8'h00, 8'd1,  7'h00, 16'd0},
    '{1'b1, 1'b0, 24'h000400, 8'h77, 8'd4,  7'h00, 16'd7},
    '{1'b1, 1'b1, 24'h000401, 8'h88, 8'd4,  7'h00, 16'd8},
    '{1'b0, 1'b0, 24'h030000, 8'h00, 8'd0,  7'h7F, 16'd40}
  };

  logic          clk = 1'b0;
  logic          rst = 1'b1;
  logic          start = 1'b0;
  logic          op = 1'b0;
  logic          wide16 = 1'b0;
  logic [AW-1:0] addr = '0;
  logic [7:0]    data = '0;
  logic [TW-1:0] erase_limit = '0;
  logic [TW-1:0] prog_limit = '0;
  logic          bus_wr;
  logic          bus_rd;
  logic [AW-1:0] bus_addr;
  logic [7:0]    bus_wdata;
  logic [7:0]    bus_rdata = 8'h00;
  logic          busy;
  logic          done;
  logic [1:0]    result;
  logic [7:0]    status;

  int nchecks = 0;
  int nerrs = 0;

  // bench flash model state
  int          wn = 0;
  int          rn = 0;
  logic [23:0] wa [8];
  logic [7:0]  wd [8];
  logic [23:0] exp_raddr = '0;
  bit          rd_bad = 1'b0;
  int          cur_nbusy = 0;
  logic [6:0]  cur_fail = '0;

  always #4 clk = ~clk;

  flashseq_engine #(.AW(AW), .TW(TW), .CMD_OFS(CMD_OFS)) i_flashseq_engine (
    .clk(clk), .rst(rst), .start(start), .op(op), .wide16(wide16),
    .addr(addr), .data(data), .erase_limit(erase_limit), .prog_limit(prog_limit),
    .bus_wr(bus_wr), .bus_rd(bus_rd), .bus_addr(bus_addr), .bus_wdata(bus_wdata),
    .bus_rdata(bus_rdata), .busy(busy), .done(done), .result(result), .status(status)
  );

  always @(posedge clk) begin
    if (!rst && bus_wr) begin
      if (wn < 8) begin
        wa[wn] = bus_addr;
        wd[wn] = bus_wdata;
      end
      wn = wn + 1;
    end
    if (!rst && bus_rd) begin
      rn = rn + 1;
      if (bus_addr != exp_raddr) rd_bad = 1'b1;
      bus_rdata <= (rn <= cur_nbusy) ? 8'h2A : {1'b1, cur_fail};
    end
  end

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    nchecks++;
    if (act !== exp) begin
      nerrs++;
      $display("FAIL %s: actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic run_vec(input vec_t v, input bit poke);
    int kt;
    bit tmo;
    int nreads;
    logic [1:0] eres;
    logic [7:0] estat;
    int nw;
    logic [23:0] ca;
    int cyc;
    kt     = (int'(v.lim) + 2) / 2;
    tmo    = int'(v.nbusy) >= kt;
    nreads = tmo ? kt : int'(v.nbusy) + 1;
    eres   = tmo ? 2'b10 : ((v.fbits != 7'd0) ? 2'b01 : 2'b00);
    estat  = tmo ? 8'h2A : {1'b1, v.fbits};
    nw     = (eres == 2'b00) ? 4 : 3;
    ca     = v.w16 ? 24'(CMD_OFS << 1) : 24'(CMD_OFS);

    @(negedge clk);
    wn = 0; rn = 0; rd_bad = 1'b0;
    cur_nbusy = int'(v.nbusy); cur_fail = v.fbits; exp_raddr = v.adr;
    op = v.op; wide16 = v.w16; addr = v.adr; data = v.dat;
    erase_limit = v.op ? '0 : TW'(v.lim);
    prog_limit  = v.op ? TW'(v.lim) : '0;
    start = 1'b1;
    @(negedge clk);
    start = 1'b0;
    chk("R12 busy after start", 32'(busy), 32'd1);
    if (poke) begin
      @(negedge clk);
      start = 1'b1; addr = 24'h555555; op = ~v.op; data = 8'h11; wide16 = ~v.w16;
      @(negedge clk);
      start = 1'b0;
    end
    cyc = 0;
    while (!done && cyc < 1000) begin
      @(negedge clk);
      cyc++;
    end
    chk("R12 done seen", 32'(done), 32'd1);
    chk("R6 R7 R8 result", 32'(result), 32'(eres));
    chk("R10 status", 32'(status), 32'(estat));
    chk("R2 R6 write count", 32'(wn), 32'(nw));
    chk("R2 opening addr", 32'(wa[0]), 32'(ca));
    chk("R2 opening data", 32'(wd[0]), 32'hFF);
    chk(v.op ? "R4 first addr" : "R3 first addr", 32'(wa[1]), 32'(v.adr));
    chk(v.op ? "R4 first data" : "R3 first data", 32'(wd[1]), v.op ? 32'h40 : 32'h20);
    chk(v.op ? "R4 second addr" : "R3 second addr", 32'(wa[2]), 32'(v.adr));
    chk(v.op ? "R4 second data" : "R3 second data", 32'(wd[2]), v.op ? 32'(v.dat) : 32'hD0);
    if (nw == 4) begin
      chk("R6 closing addr", 32'(wa[3]), 32'(ca));
      chk("R6 closing data", 32'(wd[3]), 32'hFF);
    end
    chk("R8 R9 read count", 32'(rn), 32'(nreads));
    chk("R5 read address", 32'(rd_bad), 32'd0);
    @(negedge clk);
    chk("R12 done one cycle", 32'(done), 32'd0);
    chk("R12 idle after done", 32'(busy), 32'd0);
    chk("R10 status held", 32'(status), 32'(estat));
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    nerrs++;
    nchecks++;
    $display("FAIL watchdog: actual=hung expected=finished");
    $display("Result: errors=%0d of %0d checks", nerrs, nchecks);
    $finish;
  end

  initial begin
    repeat (4) @(negedge clk);
    chk("R1 busy in reset", 32'(busy), 32'd0);
    chk("R1 wr in reset", 32'(bus_wr), 32'd0);
    rst = 1'b0;
    @(negedge clk);
    chk("R1 busy", 32'(busy), 32'd0);
    chk("R1 done", 32'(done), 32'd0);
    chk("R1 strobes", 32'({bus_wr, bus_rd}), 32'd0);
    chk("R1 result", 32'(result), 32'd0);
    chk("R1 status", 32'(status), 32'd0);

    for (int i = 0; i < NV; i++) begin
      run_vec(VECS[i], 1'b0);
    end

    // R11: start pulse in mid-operation with changed inputs
    run_vec(VECS[0], 1'b1);
    run_vec(VECS[1], 1'b1);

    // R1: reset in the middle of an operation returns to the reset state
    @(negedge clk);
    cur_nbusy = 50; exp_raddr = 24'h000100;
    op = 1'b0; wide16 = 1'b0; addr = 24'h000100; erase_limit = 24'd1000;
    start = 1'b1;
    @(negedge clk);
    start = 1'b0;
    repeat (6) @(negedge clk);
    rst = 1'b1;
    @(negedge clk);
    rst = 1'b0;
    chk("R1 busy after mid reset", 32'(busy), 32'd0);
    chk("R1 strobes after mid reset", 32'({bus_wr, bus_rd}), 32'd0);
    chk("R1 status after mid reset", 32'(status), 32'd0);

    $display("Result: errors=%0d of %0d checks", nerrs, nchecks);
    $finish;
  end

endmodule